// File: doc/BRIEF.md
# Clock Source Sequencer

This block is the control core of a clock-management peripheral. It sequences three clock sources: a high-frequency crystal, a PLL and a low-frequency clock. It also runs two one-shot jobs, an RC calibration and a crystal tune. Work is requested by single-cycle task pulses. Completion is reported by single-cycle event pulses, each of which also sets a sticky flag that can raise a level interrupt.

Each clock is tracked through four states: off, rising, on and falling. A RUN bit follows the request at once. A STAT bit changes only when the matching start or stop completes. The completion latency of every operation is a parameter. When several operations become due in the same cycle, only one of them completes per cycle, and a fixed order decides which. The low-frequency clock captures its source selection when it is started and reports that selection once it is running.

The task, event and interrupt pins are plain control signals. The register port is a single-cycle write strobe with a combinational read of the addressed register. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `clkctl_core`

## Requirements
- R1: After reset, every clock is off with RUN and STAT at 0, no one-shot is busy, and all flags, enables, the warning bit, the source registers, `irq` and `evt_pulse` are 0.
- R2: A start task for a clock (bit 0 crystal, 1 PLL, 2 low-frequency of `task_start`) is taken only in the off or falling state. It enters rising, sets RUN (register 5, bit = clock index) and reloads the latency counter. In the rising or on state it is ignored.
- R3: A stop task is taken only in the rising or on state. It enters falling and clears RUN. In the off or falling state it is ignored.
- R4: A clock with latency L whose task is taken at edge k completes at edge k+L, unless it is held back by R10 or a newer task is taken first. A start completion sets STAT bit 0 (register 6 crystal, 7 PLL) and pulses event bit 0/1/2. A stop completion clears STAT and raises no event.
- R5: A taken low-frequency start copies the source select (register 9, low bits) into the copy register (10). On start completion, register 8 shows state in bit 0 and the copied source in bits 9:8. A stop completion clears only bit 0.
- R6: A calibration task is taken when calibration is idle and completes after its latency with event bit 3. If it is taken while the crystal is not in the on state, warning register 11 bit 0 is set. That bit stays set until software writes a 0 to it.
- R7: A tune task is taken when tuning is idle and completes with event bit 4. Event bits 5 (tune error) and 6 (tune failed) are never raised.
- R8: Event flags (register 4) are sticky. A write clears each flag whose data bit is 0 and keeps each flag whose data bit is 1. An event arriving in the same cycle as a clear wins. Register 3 reads flags AND enables, and `irq` is high exactly when that value is non-zero.
- R9: Interrupt enables are loaded directly by a write to register 0. A write to register 1 sets, and a write to register 2 clears, the enable bits whose data bit is 1; data bits at 0 leave enables unchanged.
- R10: Among operations that are due, only one completes per edge, in the order crystal, PLL, low-frequency clock, calibration, tune. The others wait at zero and complete on later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_start | input | 3 | Start task pulses, one per clock |
| task_stop | input | 3 | Stop task pulses, one per clock |
| task_cal | input | 1 | Calibration task pulse |
| task_tune | input | 1 | Crystal tune task pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read of the addressed register |
| evt_pulse | output | 7 | Single-cycle completion events |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that task inputs are pulses sampled at the clock edge. They also assume that the RUN bit of a clock is the only state they need to judge whether a start or stop request will be taken. A start and a stop for the same clock may arrive together, and never more than one of them is taken. The stimulus drives every input half a cycle before the sampling edge and drops each task after one cycle. It issues register writes only to mapped addresses, so the checked relationships between tasks, RUN, STAT, events and the interrupt always see well-formed input.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  typedef enum logic [1:0] {
    CK_OFF     = 2'd0,
    CK_RISING  = 2'd1,
    CK_ON      = 2'd2,
    CK_FALLING = 2'd3
  } ck_state_e;

  localparam int NUM_CLK = 3;
  localparam int NUM_OPS = NUM_CLK + 2;
  localparam int NUM_EV  = NUM_OPS + 2;

  localparam int CK_XO  = 0;
  localparam int CK_PLL = 1;
  localparam int CK_LF  = 2;

  localparam logic [3:0] A_IEN     = 4'd0;
  localparam logic [3:0] A_IEN_SET = 4'd1;
  localparam logic [3:0] A_IEN_CLR = 4'd2;
  localparam logic [3:0] A_PEND    = 4'd3;
  localparam logic [3:0] A_FLAGS   = 4'd4;
  localparam logic [3:0] A_RUN     = 4'd5;
  localparam logic [3:0] A_ST_XO   = 4'd6;
  localparam logic [3:0] A_ST_PLL  = 4'd7;
  localparam logic [3:0] A_ST_LF   = 4'd8;
  localparam logic [3:0] A_SRC     = 4'd9;
  localparam logic [3:0] A_SRCCPY  = 4'd10;
  localparam logic [3:0] A_WARN    = 4'd11;

  localparam int LF_SRC_LSB = 8;
endpackage

// File: rtl/clkctl_clk_fsm.sv
module clkctl_clk_fsm
  import clkctl_pkg::*;
#(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  input  logic grant_i,
  output logic on_o,
  output logic run_o,
  output logic stat_o,
  output logic start_acc_o,
  output logic ready_o,
  output logic up_done_o
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(LAT - 1);

  ck_state_e   st_q;
  logic [CW-1:0] cnt_q;
  logic        run_q, stat_q;
  logic        stop_acc, moving, fire;

  assign start_acc_o = start_i && (st_q == CK_OFF || st_q == CK_FALLING);
  assign stop_acc    = stop_i && (st_q == CK_ON || st_q == CK_RISING);
  assign moving      = (st_q == CK_RISING) || (st_q == CK_FALLING);
  assign ready_o     = moving && (cnt_q == '0) && !start_acc_o && !stop_acc;
  assign fire        = ready_o && grant_i;
  assign up_done_o   = fire && (st_q == CK_RISING);
  assign on_o        = (st_q == CK_ON);
  assign run_o       = run_q;
  assign stat_o      = stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CK_OFF;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      stat_q <= 1'b0;
    end else if (start_acc_o) begin
      st_q  <= CK_RISING;
      run_q <= 1'b1;
      cnt_q <= RELOAD;
    end else if (stop_acc) begin
      st_q  <= CK_FALLING;
      run_q <= 1'b0;
      cnt_q <= RELOAD;
    end else if (fire) begin
      if (st_q == CK_RISING) begin
        st_q   <= CK_ON;
        stat_q <= 1'b1;
      end else begin
        st_q   <= CK_OFF;
        stat_q <= 1'b0;
      end
    end else if (moving && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/clkctl_oneshot.sv
module clkctl_oneshot #(
  parameter int LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic grant_i,
  output logic acc_o,
  output logic ready_o,
  output logic done_o
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(LAT - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  assign acc_o   = trig_i && !busy_q;
  assign ready_o = busy_q && (cnt_q == '0);
  assign done_o  = ready_o && grant_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (acc_o) begin
      busy_q <= 1'b1;
      cnt_q  <= RELOAD;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/clkctl_irq.sv
module clkctl_irq #(
  parameter int NEV = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ien_wr,
  input  logic           ien_set,
  input  logic           ien_clr,
  input  logic           flag_wr,
  input  logic [NEV-1:0] wdata,
  input  logic [NEV-1:0] ev_set,
  output logic [NEV-1:0] ien_o,
  output logic [NEV-1:0] flags_o,
  output logic [NEV-1:0] pend_o,
  output logic           irq_o
);
  logic [NEV-1:0] ien_q, flags_q, kept;

  assign kept    = flag_wr ? (flags_q & wdata) : flags_q;
  assign ien_o   = ien_q;
  assign flags_o = flags_q;
  assign pend_o  = flags_q & ien_q;
  assign irq_o   = |pend_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q   <= '0;
      flags_q <= '0;
    end else begin
      flags_q <= kept | ev_set;
      if (ien_wr)       ien_q <= wdata;
      else if (ien_set) ien_q <= ien_q | wdata;
      else if (ien_clr) ien_q <= ien_q & ~wdata;
    end
  end
endmodule

// File: rtl/clkctl_core.sv
module clkctl_core
  import clkctl_pkg::*;
#(
  parameter int LAT_XO   = 1,
  parameter int LAT_PLL  = 1,
  parameter int LAT_LF   = 1,
  parameter int LAT_CAL  = 1,
  parameter int LAT_TUNE = 1,
  parameter int SRC_W    = 2,
  parameter int AW       = 4,
  parameter int DW       = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLK-1:0] task_start,
  input  logic [NUM_CLK-1:0] task_stop,
  input  logic               task_cal,
  input  logic               task_tune,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic [NUM_EV-1:0]  evt_pulse,
  output logic               irq
);
  localparam int CK_LAT [NUM_CLK] = '{LAT_XO, LAT_PLL, LAT_LF};

  logic [NUM_CLK-1:0] ck_on, ck_run, ck_stat, ck_sacc, ck_rdy, ck_up;
  logic [NUM_OPS-1:0] op_rdy, op_grant;
  logic               cal_acc, cal_rdy, cal_done;
  logic               tune_acc, tune_rdy, tune_done;
  logic [NUM_EV-1:0]  ev_set, ien_q, flags_q, pend;
  logic [SRC_W-1:0]   src_sel_q, src_copy_q, src_rep_q;
  logic               warn_q;
  logic [NUM_EV-1:0]  evt_q;

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_ck
    clkctl_clk_fsm #(.LAT(CK_LAT[g])) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (task_start[g]),
      .stop_i     (task_stop[g]),
      .grant_i    (op_grant[g]),
      .on_o       (ck_on[g]),
      .run_o      (ck_run[g]),
      .stat_o     (ck_stat[g]),
      .start_acc_o(ck_sacc[g]),
      .ready_o    (ck_rdy[g]),
      .up_done_o  (ck_up[g])
    );
  end

  clkctl_oneshot #(.LAT(LAT_CAL)) u_cal (
    .clk(clk), .rst_n(rst_n), .trig_i(task_cal), .grant_i(op_grant[NUM_CLK]),
    .acc_o(cal_acc), .ready_o(cal_rdy), .done_o(cal_done)
  );

  clkctl_oneshot #(.LAT(LAT_TUNE)) u_tune (
    .clk(clk), .rst_n(rst_n), .trig_i(task_tune), .grant_i(op_grant[NUM_CLK+1]),
    .acc_o(tune_acc), .ready_o(tune_rdy), .done_o(tune_done)
  );

  // lowest index wins: crystal, PLL, low-frequency, calibration, tune
  assign op_rdy   = {tune_rdy, cal_rdy, ck_rdy};
  assign op_grant = op_rdy & (~op_rdy + 1'b1);
  assign ev_set   = {2'b00, tune_done, cal_done, ck_up};

  logic wr_ien, wr_set, wr_clr, wr_flags;
  assign wr_ien   = reg_wr && (reg_addr == A_IEN);
  assign wr_set   = reg_wr && (reg_addr == A_IEN_SET);
  assign wr_clr   = reg_wr && (reg_addr == A_IEN_CLR);
  assign wr_flags = reg_wr && (reg_addr == A_FLAGS);

  clkctl_irq #(.NEV(NUM_EV)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .ien_wr(wr_ien), .ien_set(wr_set), .ien_clr(wr_clr), .flag_wr(wr_flags),
    .wdata(reg_wdata[NUM_EV-1:0]), .ev_set(ev_set),
    .ien_o(ien_q), .flags_o(flags_q), .pend_o(pend), .irq_o(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sel_q  <= '0;
      src_copy_q <= '0;
      src_rep_q  <= '0;
      warn_q     <= 1'b0;
      evt_q      <= '0;
    end else begin
      evt_q <= ev_set;
      if (reg_wr && reg_addr == A_SRC) src_sel_q <= reg_wdata[SRC_W-1:0];
      if (ck_sacc[CK_LF]) src_copy_q <= src_sel_q;
      if (ck_up[CK_LF])   src_rep_q  <= src_copy_q;
      warn_q <= ((reg_wr && reg_addr == A_WARN) ? (warn_q & reg_wdata[0]) : warn_q)
              | (cal_acc && !ck_on[CK_XO]);
    end
  end

  assign evt_pulse = evt_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_IEN:    reg_rdata[NUM_EV-1:0]  = ien_q;
      A_PEND:   reg_rdata[NUM_EV-1:0]  = pend;
      A_FLAGS:  reg_rdata[NUM_EV-1:0]  = flags_q;
      A_RUN:    reg_rdata[NUM_CLK-1:0] = ck_run;
      A_ST_XO:  reg_rdata[0]           = ck_stat[CK_XO];
      A_ST_PLL: reg_rdata[0]           = ck_stat[CK_PLL];
      A_ST_LF: begin
        reg_rdata[0]                       = ck_stat[CK_LF];
        reg_rdata[LF_SRC_LSB +: SRC_W]     = src_rep_q;
      end
      A_SRC:    reg_rdata[SRC_W-1:0]   = src_sel_q;
      A_SRCCPY: reg_rdata[SRC_W-1:0]   = src_copy_q;
      A_WARN:   reg_rdata[0]           = warn_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/clkctl_core_chk.sv
module clkctl_core_chk #(
  parameter int NC = 3,
  parameter int NE = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NC-1:0] task_start,
  input logic [NC-1:0] task_stop,
  input logic [NC-1:0] run,
  input logic [NC-1:0] stat,
  input logic [NE-1:0] evt,
  input logic [NE-1:0] ien,
  input logic          irq
);
  // R2
  xo_start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && task_start[0]) |=> run[0]);
  // R2
  lf_start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[2] && task_start[2]) |=> run[2]);
  // R3
  pll_stop_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run[1] && task_stop[1]) |=> !run[1]);
  // R4
  xo_event_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[0] |-> stat[0]);
  // R4
  pll_event_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt[1] |-> stat[1]);
  // R10
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(evt));
  // R8
  enabled_event_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt & ien)) |-> irq);
endmodule

bind clkctl_core clkctl_core_chk #(.NC(clkctl_pkg::NUM_CLK), .NE(clkctl_pkg::NUM_EV)) u_chk (
  .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
  .run(ck_run), .stat(ck_stat), .evt(evt_pulse), .ien(ien_q), .irq(irq)
);

// File: tb/tb_clkctl_core.sv
`timescale 1ns/1ps
module tb_clkctl_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  task_start = '0, task_stop = '0;
  logic        task_cal = 1'b0, task_tune = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [6:0]  evt_pulse;
  logic        irq;

  always #4 clk = ~clk;

  clkctl_core #(.LAT_XO(1), .LAT_PLL(2), .LAT_LF(3), .LAT_CAL(1), .LAT_TUNE(2)) dut (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
    .task_cal(task_cal), .task_tune(task_tune), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq(irq)
  );

  // reference model; states: 0 off, 1 rising, 2 on, 3 falling
  int lat [5] = '{1, 2, 3, 1, 2};
  int m_st [3] = '{0, 0, 0};
  int m_cnt [5] = '{0, 0, 0, 0, 0};
  int m_run [3] = '{0, 0, 0};
  int m_stat [3] = '{0, 0, 0};
  int m_busy [2] = '{0, 0};
  int m_ien = 0, m_flags = 0, m_src = 0, m_copy = 0, m_rep = 0, m_warn = 0, m_evt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_st[i] = 0; m_run[i] = 0; m_stat[i] = 0; end
      for (int i = 0; i < 5; i++) m_cnt[i] = 0;
      m_busy[0] = 0; m_busy[1] = 0;
      m_ien = 0; m_flags = 0; m_src = 0; m_copy = 0; m_rep = 0; m_warn = 0; m_evt = 0;
    end else begin
      int go [3];
      int halt [3];
      int due [5];
      int win;
      int nev;
      int os_acc [2];
      int wset;
      win = -1; nev = 0;
      for (int i = 0; i < 3; i++) begin
        go[i]   = task_start[i] && (m_st[i] == 0 || m_st[i] == 3);
        halt[i] = task_stop[i] && (m_st[i] == 1 || m_st[i] == 2);
        due[i]  = (m_st[i] == 1 || m_st[i] == 3) && m_cnt[i] == 0 && !go[i] && !halt[i];
      end
      os_acc[0] = task_cal && !m_busy[0];
      os_acc[1] = task_tune && !m_busy[1];
      due[3] = m_busy[0] && m_cnt[3] == 0;
      due[4] = m_busy[1] && m_cnt[4] == 0;
      for (int i = 4; i >= 0; i--) if (due[i]) win = i;
      wset = os_acc[0] && m_st[0] != 2;
      for (int i = 0; i < 3; i++) begin
        if (go[i]) begin
          m_st[i] = 1; m_run[i] = 1; m_cnt[i] = lat[i] - 1;
          if (i == 2) m_copy = m_src;
        end else if (halt[i]) begin
          m_st[i] = 3; m_run[i] = 0; m_cnt[i] = lat[i] - 1;
        end else if (win == i) begin
          if (m_st[i] == 1) begin
            m_st[i] = 2; m_stat[i] = 1; nev |= (1 << i);
            if (i == 2) m_rep = m_copy;
          end else begin
            m_st[i] = 0; m_stat[i] = 0;
          end
        end else if ((m_st[i] == 1 || m_st[i] == 3) && m_cnt[i] > 0) m_cnt[i]--;
      end
      for (int k = 0; k < 2; k++) begin
        if (os_acc[k]) begin m_busy[k] = 1; m_cnt[3+k] = lat[3+k] - 1; end
        else if (win == 3 + k) begin m_busy[k] = 0; nev |= (1 << (3 + k)); end
        else if (m_busy[k] && m_cnt[3+k] > 0) m_cnt[3+k]--;
      end
      if (reg_wr) begin
        case (reg_addr)
          4'd0: m_ien = reg_wdata[6:0];
          4'd1: m_ien = m_ien | reg_wdata[6:0];
          4'd2: m_ien = m_ien & ~int'(reg_wdata[6:0]) & 7'h7f;
          4'd4: m_flags = m_flags & reg_wdata[6:0];
          4'd9: m_src = reg_wdata[1:0];
          4'd11: m_warn = m_warn & reg_wdata[0];
          default: ;
        endcase
      end
      m_flags = m_flags | nev;
      m_warn = m_warn | wset;
      m_evt = nev;
    end
  end

  function automatic logic [15:0] exp_rd(input logic [3:0] a);
    case (a)
      4'd0: return 16'(m_ien);
      4'd3: return 16'(m_flags & m_ien);
      4'd4: return 16'(m_flags);
      4'd5: return 16'(m_run[0] | (m_run[1] << 1) | (m_run[2] << 2));
      4'd6: return 16'(m_stat[0]);
      4'd7: return 16'(m_stat[1]);
      4'd8: return 16'(m_stat[2] | (m_rep << 8));
      4'd9: return 16'(m_src);
      4'd10: return 16'(m_copy);
      4'd11: return 16'(m_warn);
      default: return 16'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0, 4'd1, 4'd2: return "R9";
      4'd3, 4'd4: return "R8";
      4'd5: return "R2";
      4'd6, 4'd7: return "R4";
      4'd8, 4'd9, 4'd10: return "R5";
      4'd11: return "R6";
      default: return "R1";
    endcase
  endfunction

  int vectors = 0, miscompares = 0, rp = 0;
  string phase = "R1";
  bit finished = 1'b0;

  task automatic chk(input string what, input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s [%s, phase %s] at %0t: actual %0h expected %0h", req, what, phase, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("reg_rdata", tag_of(reg_addr), reg_rdata, exp_rd(reg_addr));
    chk("irq", "R8", 16'(irq), 16'(((m_flags & m_ien) != 0) ? 1 : 0));
    chk("evt_pulse", "R4", 16'(evt_pulse), 16'(m_evt));
    task_start = '0; task_stop = '0; task_cal = 1'b0; task_tune = 1'b0;
    reg_wr = 1'b0; reg_wdata = '0;
    reg_addr = 4'(rp); rp = (rp + 1) % 12;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
  endtask

  initial begin
    // R1: reset values on every register while reset is held and after release
    idle(4);
    rst_n = 1'b1;
    for (int a = 0; a < 12; a++) begin reg_addr = 4'(a); tick(); end
    phase = "R9"; wr(4'd1, 16'h007f); wr(4'd2, 16'h0040); idle(2);
    phase = "R2"; task_start[0] = 1'b1; tick(); idle(3);
    task_start[0] = 1'b1; tick(); idle(2);              // ignored in on state
    phase = "R3"; task_stop[0] = 1'b1; tick(); idle(2);
    task_stop[0] = 1'b1; tick(); idle(2);               // ignored in off state
    phase = "R4"; task_start[1] = 1'b1; tick(); task_stop[1] = 1'b1; tick();
    task_start[1] = 1'b1; tick(); idle(4);              // restart while falling
    task_start[1] = 1'b1; task_stop[1] = 1'b1; tick(); idle(3);
    phase = "R5"; wr(4'd9, 16'h0002); task_start[2] = 1'b1; tick();
    wr(4'd9, 16'h0001); idle(4); task_stop[2] = 1'b1; tick(); idle(5);
    task_start[2] = 1'b1; tick(); idle(6);
    phase = "R6"; task_stop[0] = 1'b1; tick(); idle(1);
    task_cal = 1'b1; tick(); task_cal = 1'b1; tick(); idle(3);
    wr(4'd11, 16'h0000); idle(2);
    task_start[0] = 1'b1; tick(); idle(2); task_cal = 1'b1; tick(); idle(3);
    phase = "R7"; task_tune = 1'b1; tick(); task_tune = 1'b1; tick(); idle(4);
    phase = "R8"; wr(4'd4, 16'h0055); idle(2); wr(4'd4, 16'h0000); idle(2);
    task_cal = 1'b1; tick(); wr(4'd4, 16'h0000); idle(3);
    phase = "R9"; wr(4'd0, 16'h0008); idle(2); wr(4'd2, 16'h0008); idle(2);
    wr(4'd1, 16'h0000); idle(2); wr(4'd1, 16'h001f); idle(2);
    phase = "R10"; task_stop[0] = 1'b1; tick(); idle(2);
    task_start[0] = 1'b1; task_cal = 1'b1; tick(); idle(4);
    task_stop[2] = 1'b1; tick(); idle(5);
    task_start[2] = 1'b1; tick(); task_tune = 1'b1; tick(); idle(6);
    task_start[1] = 1'b1; task_stop[0] = 1'b1; task_stop[2] = 1'b1; tick(); idle(6);
    for (int a = 0; a < 12; a++) begin reg_addr = 4'(a); tick(); end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule